// File: doc/BRIEF.md
# Three-Axis Sample Ready and Overwrite Status Tracker

This block holds the latest three-axis sample set and keeps the status byte that tells a host which axes carry fresh data and which were overwritten before the host fetched them. One strobe captures all three 16-bit samples at once. The host reads bytes through a narrow read port. Each read either names an address with a seek strobe or takes the next address from an internal pointer that advances after every read. A mode input chooses where that pointer goes after the last data byte: back to the status byte, or back to the first data byte. The second choice allows endless sample-only bursts.

Each axis has its own ready flag. Reading that axis's high byte clears it. A combined ready flag stays up until all three high bytes have been fetched. An overwrite flag records a capture that arrived while the earlier data was still unread. Reading the status byte clears the overwrite flags.

Top module: `axis_rdy_tracker`

## Requirements
- R1: A synchronous reset clears the whole status byte to 0x00 and drops rd_valid. After reset the read pointer is at address 0x00, so a read without seek returns the status byte.
- R2: The status byte has X, Y and Z ready in bits 0, 1 and 2, combined ready in bit 3, X, Y and Z overwrite in bits 4, 5 and 6, and combined overwrite in bit 7. A capture strobe sets bits 0 to 3 from the next cycle on.
- R3: An axis ready flag clears when that axis high byte is read (X at 0x01, Y at 0x03, Z at 0x05). Reading a low byte (0x02, 0x04, 0x06) leaves every ready flag unchanged.
- R4: Combined ready stays set while any axis ready flag is set. It clears in the cycle after the last of the three high bytes is read.
- R5: An axis overwrite flag sets when a capture arrives while that axis ready flag is still set.
- R6: Combined overwrite sets when a capture arrives while combined ready is still set.
- R7: A read of address 0x00 clears all four overwrite bits and leaves the ready bits unchanged.
- R8: When a capture and a clearing read fall in the same cycle, the capture wins. The ready flag stays set, and the overwrite flag sets if the ready flag was set before that cycle.
- R9: rd_data and rd_valid appear one cycle after rd_en. The value is the one held before that edge. 0x00 gives status, 0x01 to 0x06 give X high, X low, Y high, Y low, Z high, Z low, and any other address gives 0x00.
- R10: After each read the pointer moves to the next address. After a read of 0x06 or any higher address it moves to 0x00 when wrap_to_data is 0 and to 0x01 when wrap_to_data is 1.
- R11: With rd_seek high, a read uses rd_addr in place of the pointer. The pointer then continues from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_valid | input | 1 | Capture strobe for a new sample set |
| acq_x | input | 16 | X sample |
| acq_y | input | 16 | Y sample |
| acq_z | input | 16 | Z sample |
| rd_en | input | 1 | Read one byte |
| rd_seek | input | 1 | Use rd_addr for this read instead of the pointer |
| rd_addr | input | 8 | Explicit read address |
| wrap_to_data | input | 1 | Pointer target after the last data byte: 0 selects status, 1 selects the first data byte |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | rd_data is valid |
| status | output | 8 | Live status byte |

## Verification
The hardest cases are the same-cycle collisions. A capture can land in the very cycle that a high-byte read or a status read would clear a flag. That cycle is only reached by driving the strobe and the read together on one edge while a flag from an earlier capture is still pending. The stimulus therefore leaves data unread on purpose first, then drives both inputs together. A second awkward case is a partly drained set. Only the X high byte is fetched before the next capture. This separates the per-axis overwrite flags from the combined one, so the status byte shows 0xEF.

// File: rtl/axis_rdy_pkg.sv
package axis_rdy_pkg;

    localparam int NUM_AXES  = 3;
    localparam int STAT_ADDR = 0;
    localparam int DATA_LO   = 1;
    localparam int DATA_HI   = 2 * NUM_AXES;

    typedef struct packed {
        logic            all_ow;
        logic [2:0]      ow;
        logic            all_rdy;
        logic [2:0]      rdy;
    } status_t;

    function automatic int unsigned next_addr(input int unsigned a, input logic wrap_data);
        if (a >= DATA_HI)
            return wrap_data ? DATA_LO : STAT_ADDR;
        return a + 1;
    endfunction

    function automatic int unsigned hi_addr_of(input int axis);
        return DATA_LO + 2 * axis;
    endfunction

endpackage

// File: rtl/axis_slot.sv
module axis_slot #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acq,
    input  logic [2*BYTE_W-1:0]   sample_in,
    input  logic                  hi_rd,
    input  logic                  st_rd,
    output logic                  rdy,
    output logic                  ow,
    output logic [BYTE_W-1:0]     hi_byte,
    output logic [BYTE_W-1:0]     lo_byte
);
    logic [2*BYTE_W-1:0] sample_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= '0;
            rdy      <= 1'b0;
            ow       <= 1'b0;
        end else begin
            if (acq) sample_q <= sample_in;
            if (acq)        rdy <= 1'b1;
            else if (hi_rd) rdy <= 1'b0;
            if (acq && rdy) ow <= 1'b1;
            else if (st_rd) ow <= 1'b0;
        end
    end

    assign hi_byte = sample_q[2*BYTE_W-1:BYTE_W];
    assign lo_byte = sample_q[BYTE_W-1:0];
endmodule

// File: rtl/set_flags.sv
module set_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         acq,
    input  logic         st_rd,
    input  logic [N-1:0] rdy,
    input  logic [N-1:0] hi_rd,
    output logic         all_rdy,
    output logic         all_ow
);
    logic pending_left;
    assign pending_left = |(rdy & ~hi_rd);

    always_ff @(posedge clk) begin
        if (rst) begin
            all_rdy <= 1'b0;
            all_ow  <= 1'b0;
        end else begin
            all_rdy <= acq | (all_rdy & pending_left);
            if (acq && all_rdy) all_ow <= 1'b1;
            else if (st_rd)     all_ow <= 1'b0;
        end
    end
endmodule

// File: rtl/burst_ptr.sv
module burst_ptr
    import axis_rdy_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              rd_seek,
    input  logic [ADDR_W-1:0] seek_addr,
    input  logic              wrap_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] ptr
);
    assign cur_addr = rd_seek ? seek_addr : ptr;

    always_ff @(posedge clk) begin
        if (rst)        ptr <= ADDR_W'(STAT_ADDR);
        else if (rd_en) ptr <= ADDR_W'(next_addr(int'(cur_addr), wrap_data));
    end
endmodule

// File: rtl/axis_rdy_tracker.sv
module axis_rdy_tracker
    import axis_rdy_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acq_valid,
    input  logic [2*BYTE_W-1:0] acq_x,
    input  logic [2*BYTE_W-1:0] acq_y,
    input  logic [2*BYTE_W-1:0] acq_z,
    input  logic                rd_en,
    input  logic                rd_seek,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                wrap_to_data,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                rd_valid,
    output logic [7:0]          status
);
    localparam int SW = 2 * BYTE_W;

    logic [ADDR_W-1:0]   cur_addr;
    logic [ADDR_W-1:0]   ptr;
    logic [SW-1:0]       samples [NUM_AXES];
    logic [NUM_AXES-1:0] rdy, ow, hi_rd;
    logic [BYTE_W-1:0]   hi_b [NUM_AXES];
    logic [BYTE_W-1:0]   lo_b [NUM_AXES];
    logic                st_rd, all_rdy, all_ow;
    status_t             stat;
    logic [BYTE_W-1:0]   rd_byte;

    assign samples[0] = acq_x;
    assign samples[1] = acq_y;
    assign samples[2] = acq_z;

    burst_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_seek(rd_seek),
        .seek_addr(rd_addr), .wrap_data(wrap_to_data),
        .cur_addr(cur_addr), .ptr(ptr)
    );

    assign st_rd = rd_en && (cur_addr == ADDR_W'(STAT_ADDR));

    for (genvar i = 0; i < NUM_AXES; i++) begin : g_axis
        assign hi_rd[i] = rd_en && (cur_addr == ADDR_W'(hi_addr_of(i)));
        axis_slot #(.BYTE_W(BYTE_W)) u_slot (
            .clk(clk), .rst(rst), .acq(acq_valid), .sample_in(samples[i]),
            .hi_rd(hi_rd[i]), .st_rd(st_rd), .rdy(rdy[i]), .ow(ow[i]),
            .hi_byte(hi_b[i]), .lo_byte(lo_b[i])
        );
    end

    set_flags #(.N(NUM_AXES)) u_set (
        .clk(clk), .rst(rst), .acq(acq_valid), .st_rd(st_rd),
        .rdy(rdy), .hi_rd(hi_rd), .all_rdy(all_rdy), .all_ow(all_ow)
    );

    always_comb begin
        stat.rdy     = rdy;
        stat.all_rdy = all_rdy;
        stat.ow      = ow;
        stat.all_ow  = all_ow;
    end
    assign status = stat;

    always_comb begin
        rd_byte = '0;
        if (cur_addr == ADDR_W'(STAT_ADDR)) rd_byte = BYTE_W'(status);
        for (int i = 0; i < NUM_AXES; i++) begin
            if (cur_addr == ADDR_W'(hi_addr_of(i)))     rd_byte = hi_b[i];
            if (cur_addr == ADDR_W'(hi_addr_of(i) + 1)) rd_byte = lo_b[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_byte;
        end
    end
endmodule

// File: rtl/axis_rdy_tracker_chk.sv
module axis_rdy_tracker_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              acq_valid,
    input logic              rd_en,
    input logic              wrap_to_data,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [ADDR_W-1:0] ptr,
    input logic [7:0]        status,
    input logic              rd_valid
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (status == 8'h00) && !rd_valid && (ptr == '0)); // R1

    AST_ACQ_SETS_READY: assert property (@(posedge clk) disable iff (rst)
        acq_valid |=> (status[3:0] == 4'hF)); // R2

    AST_HI_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rd_en && !acq_valid && (cur_addr == ADDR_W'(1)) |=> !status[0]); // R3

    AST_COMBINED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (|status[2:0]) |-> status[3]); // R4

    AST_AXIS_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        acq_valid && status[0] |=> status[4]); // R5

    AST_SET_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        acq_valid && status[3] |=> status[7]); // R6

    AST_STATUS_READ_CLEARS_OW: assert property (@(posedge clk) disable iff (rst)
        rd_en && !acq_valid && (cur_addr == '0) |=> (status[7:4] == 4'h0)); // R7

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid); // R9

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        rd_en && (cur_addr >= ADDR_W'(6)) |=> (ptr == ($past(wrap_to_data) ? ADDR_W'(1) : ADDR_W'(0)))); // R10
endmodule

bind axis_rdy_tracker axis_rdy_tracker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .acq_valid(acq_valid), .rd_en(rd_en),
    .wrap_to_data(wrap_to_data), .cur_addr(cur_addr), .ptr(ptr),
    .status(status), .rd_valid(rd_valid)
);

// File: tb/axis_rdy_tracker_bench.sv
`timescale 1ns/1ps
module axis_rdy_tracker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acq_valid = 1'b0;
    logic [15:0] acq_x = '0, acq_y = '0, acq_z = '0;
    logic        rd_en = 1'b0, rd_seek = 1'b0, wrap_to_data = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [7:0]  status;

    always #2.5 clk = ~clk;

    axis_rdy_tracker u_axis_rdy_tracker (
        .clk(clk), .rst(rst), .acq_valid(acq_valid), .acq_x(acq_x), .acq_y(acq_y),
        .acq_z(acq_z), .rd_en(rd_en), .rd_seek(rd_seek), .rd_addr(rd_addr),
        .wrap_to_data(wrap_to_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .status(status)
    );

    typedef struct { logic [7:0] val; string tag; } exp_t;
    exp_t exp_q[$];

    int checks = 0, fails = 0;
    bit running = 0;

    // reference state, built from the requirements
    logic [15:0] m_s [3];
    logic [2:0]  m_dr, m_ow;
    logic        m_zdr, m_zow;
    logic [7:0]  m_ptr;

    function automatic logic [7:0] m_status();
        return {m_zow, m_ow, m_zdr, m_dr};
    endfunction

    function automatic logic [7:0] m_byte(input logic [7:0] a);
        if (a == 8'd0) return m_status();
        if (a >= 8'd1 && a <= 8'd6) begin
            int ax = (int'(a) - 1) / 2;
            return a[0] ? m_s[ax][15:8] : m_s[ax][7:0];
        end
        return 8'h00;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(input logic acq, input logic [15:0] x, input logic [15:0] y,
                        input logic [15:0] z, input logic rd, input logic seek,
                        input logic [7:0] addr, input logic wrap, input string tag);
        logic [7:0] a;
        logic [2:0] hir, ndr;
        logic       str;
        @(negedge clk);
        check({tag, " status"}, status, m_status());
        acq_valid = acq; acq_x = x; acq_y = y; acq_z = z;
        rd_en = rd; rd_seek = seek; rd_addr = addr; wrap_to_data = wrap;
        a = seek ? addr : m_ptr;
        hir = '0; str = 1'b0;
        if (rd) begin
            exp_t e;
            e.val = m_byte(a); e.tag = {tag, " rd_data"};
            exp_q.push_back(e);
            str = (a == 8'd0);
            for (int i = 0; i < 3; i++) hir[i] = (a == 8'(1 + 2 * i));
            m_ptr = (a >= 8'd6) ? (wrap ? 8'd1 : 8'd0) : a + 8'd1;
        end
        ndr = acq ? 3'b111 : (m_dr & ~hir);
        m_ow  = (acq ? m_dr : 3'b000) | (m_ow & {3{~str}});
        m_zow = (acq & m_zdr) | (m_zow & ~str);
        m_zdr = acq | (m_zdr & (|(m_dr & ~hir)));
        m_dr  = ndr;
        if (acq) begin m_s[0] = x; m_s[1] = y; m_s[2] = z; end
    endtask

    task automatic idle(input string tag);
        step(1'b0, '0, '0, '0, 1'b0, 1'b0, 8'h00, 1'b0, tag);
    endtask

    task automatic rd(input logic seek, input logic [7:0] addr, input logic wrap, input string tag);
        step(1'b0, '0, '0, '0, 1'b1, seek, addr, wrap, tag);
    endtask

    task automatic acq(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z, input string tag);
        step(1'b1, x, y, z, 1'b0, 1'b0, 8'h00, 1'b0, tag);
    endtask

    // monitor: pop expected bytes as the design delivers them
    always @(negedge clk) begin
        if (running && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9: actual rd_valid=1 expected no read pending");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, rd_data, e.val);
            end
        end
    end

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) m_s[i] = '0;
        m_dr = '0; m_ow = '0; m_zdr = 0; m_zow = 0; m_ptr = 8'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        running = 1;
        checks++;
        if (rd_valid !== 1'b0) begin fails++; $display("FAIL R1: actual rd_valid=%b expected 0", rd_valid); end

        // R1: reset state, pointer reads status first
        rd(1'b0, 8'h00, 1'b0, "R1");
        // R2: capture sets ready bits 0..3
        acq(16'h1234, 16'h5678, 16'h9ABC, "R2");
        idle("R2");
        // R9/R10/R3/R4: full burst from status, wrap to status
        rd(1'b1, 8'h00, 1'b0, "R11");
        for (int k = 0; k < 7; k++) rd(1'b0, 8'h00, 1'b0, "R10 R9 R3 R4");
        idle("R4");
        // R5/R6: two captures unread, then R7 status read clears overwrite
        acq(16'hA1B2, 16'hC3D4, 16'hE5F6, "R5");
        acq(16'h0102, 16'h0304, 16'h0506, "R6");
        idle("R5 R6");
        rd(1'b1, 8'h00, 1'b0, "R7");
        idle("R7");
        // partial drain: X high only, then capture -> 0xEF
        rd(1'b1, 8'h01, 1'b0, "R3");
        rd(1'b1, 8'h02, 1'b0, "R3 low byte");
        acq(16'h1111, 16'h2222, 16'h3333, "R5 R6");
        idle("R5 R6 partial");
        // R8: capture with status read in the same cycle
        step(1'b1, 16'h4444, 16'h5555, 16'h6666, 1'b1, 1'b1, 8'h00, 1'b0, "R8 status");
        idle("R8");
        rd(1'b1, 8'h00, 1'b0, "R7");
        // R8: capture with X high read in the same cycle
        step(1'b1, 16'h7788, 16'h99AA, 16'hBBCC, 1'b1, 1'b1, 8'h01, 1'b0, "R8 hi");
        idle("R8");
        // R10: wrap to first data byte
        rd(1'b1, 8'h05, 1'b1, "R11");
        rd(1'b0, 8'h00, 1'b1, "R10");
        rd(1'b0, 8'h00, 1'b1, "R10 wrap data");
        rd(1'b0, 8'h00, 1'b1, "R10");
        // R9: unmapped address reads zero, then pointer wraps to status
        rd(1'b1, 8'h09, 1'b0, "R9 unmapped");
        rd(1'b0, 8'h00, 1'b0, "R10 wrap status");
        idle("R9");
        idle("end");
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R9: actual %0d reads missing expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule